// File: doc/BRIEF.md
# Nibble-Serial Peripheral Reader (Three-Line Handshake)

This block is the host side of a three-wire handshake that pulls a short message out of a peripheral, four bits at a time, over a general-purpose port. The host owns two lines: an active-low select and a toggle. The peripheral answers on an acknowledge line and a 4-bit data bus. The data bus holds a valid nibble only while the acknowledge line equals the toggle line. When the two lines differ, the value on the bus has no meaning and is never taken.

A one-cycle start request makes the reader pull both host lines low. The reader then collects nibbles one at a time. The first nibble is the device identifier. The second is a byte count. After those comes a payload of two nibbles per byte, with the byte count capped by a build-time limit. The payload is packed into a flat byte buffer. At the end the reader releases both lines high and pulses a completion strobe. If the peripheral fails to follow the toggle within a programmable number of cycles, the reader abandons the read, releases the lines and pulses an error strobe instead.

Top module: `nib_handshake_reader`

## Requirements
- R1: After reset and whenever no read is in progress, `sel_n_o` and `tog_o` are both 1. After reset, `done_o`, `err_o`, `id_o`, `len_o` and `payload_o` are all 0.
- R2: A `start_i` seen on a clock edge while idle drives `sel_n_o` and `tog_o` to 0 after that edge. A `start_i` seen while a read is in progress has no effect on that read.
- R3: A nibble is taken only on an edge where `ack_i` equals `tog_o`. After each nibble that is not the last, `tog_o` is inverted. Values on `data_i` while `ack_i` differs from `tog_o` never reach any output.
- R4: The first nibble taken is reported on `id_o` and the second on `len_o`. Both are valid while `done_o` is high.
- R5: After the two header nibbles, exactly 2*min(`len`, MAX_BYTES) payload nibbles are read. After the last one, the read ends.
- R6: Payload byte k sits at `payload_o[8k+7:8k]`. Its upper four bits are payload nibble 2k and its lower four bits are payload nibble 2k+1, counting from 0 after the header. Bytes that were not received read 0, because the buffer clears when a read is accepted.
- R7: If `ack_i` differs from `tog_o` on `timeout_i` consecutive edges during one wait, the read is abandoned. `err_o` pulses for one cycle, both host lines return to 1, and `done_o` is not raised. With a peripheral that never answers, `err_o` goes high after the `timeout_i`-th edge following the start edge.
- R8: `done_o` is a one-cycle pulse. It goes high on the edge that takes the final nibble, and in that same cycle `sel_n_o` and `tog_o` are already 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin a read (sampled while idle) |
| timeout_i | input | TMO_W | Number of mismatched cycles allowed per wait (nonzero) |
| ack_i | input | 1 | Acknowledge line from the peripheral |
| data_i | input | 4 | Nibble bus from the peripheral |
| sel_n_o | output | 1 | Active-low device select |
| tog_o | output | 1 | Toggle line to the peripheral |
| done_o | output | 1 | One-cycle pulse when a read completes |
| err_o | output | 1 | One-cycle pulse when a read is abandoned |
| id_o | output | 4 | Device identifier nibble |
| len_o | output | 4 | Byte-count nibble as received |
| payload_o | output | 8*MAX_BYTES | Packed payload bytes, byte 0 in the low bits |

## Verification
The assertions assume three things about the inputs. `timeout_i` is nonzero and does not change during a read. The peripheral moves `ack_i` only toward the current toggle value. `ack_i` sits at 1 while the device is deselected. The bench peripheral model follows these rules. It reacts only on falling clock edges, copies the toggle after a chosen delay, and returns to idle the moment select rises. It also drives the inverse of the correct nibble whenever the two lines differ, so that any capture made too early shows up as wrong data.

// File: rtl/hsr_pkg.sv
package hsr_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } hsr_state_t;

  // Payload nibble count for a received byte-count nibble, capped at max_bytes.
  function automatic int unsigned payload_nibbles(input logic [3:0] len,
                                                  input int unsigned max_bytes);
    int unsigned nbytes;
    nbytes = (int'(len) > int'(max_bytes)) ? max_bytes : int'(len);
    return 2 * nbytes;
  endfunction

endpackage

// File: rtl/hsr_timer.sv
module hsr_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             tick_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             expire_o
);

  logic [TMO_W-1:0] cnt_q;

  assign expire_o = tick_i && (cnt_q == limit_i - TMO_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_q + TMO_W'(1);
  end

  // A wait never runs past its limit without aborting.
  assert_below_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && limit_i != '0) |-> (cnt_q < limit_i));

endmodule

// File: rtl/hsr_packer.sv
module hsr_packer #(
  parameter int MAX_BYTES = 32,
  parameter int IDX_W     = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear_i,
  input  logic                   we_i,
  input  logic [IDX_W-1:0]       idx_i,
  input  logic [3:0]             nib_i,
  output logic [8*MAX_BYTES-1:0] payload_o
);

  localparam int BW = IDX_W - 1;

  logic [IDX_W-1:0] pos;
  logic [BW-1:0]    byte_sel;
  logic             hi_half;

  assign pos      = idx_i - IDX_W'(2);
  assign byte_sel = pos[IDX_W-1:1];
  assign hi_half  = ~pos[0];

  for (genvar b = 0; b < MAX_BYTES; b++) begin : g_byte
    logic [7:0] byte_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       byte_q <= '0;
      else if (clear_i) byte_q <= '0;
      else if (we_i && byte_sel == BW'(b)) begin
        if (hi_half) byte_q[7:4] <= nib_i;
        else         byte_q[3:0] <= nib_i;
      end
    end
    assign payload_o[8*b +: 8] = byte_q;
  end

  // Writes land only inside the buffer.
  assert_byte_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |-> (int'(byte_sel) < MAX_BYTES));

endmodule

// File: rtl/hsr_seq.sv
module hsr_seq #(
  parameter int MAX_BYTES = 32,
  parameter int IDX_W     = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             ack_i,
  input  logic [3:0]       data_i,
  input  logic             expire_i,
  output logic             sel_n_o,
  output logic             tog_o,
  output logic             launch_o,
  output logic             cap_o,
  output logic             wait_miss_o,
  output logic             idle_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             done_o,
  output logic             err_o,
  output logic [3:0]       id_o,
  output logic [3:0]       len_o
);
  import hsr_pkg::*;

  hsr_state_t       state_q;
  logic [IDX_W-1:0] idx_q;
  logic [3:0]       len_src;
  logic [IDX_W-1:0] total_nibs;
  logic             last_nib;

  assign idle_o      = (state_q == ST_IDLE);
  assign launch_o    = idle_o && start_i;
  assign cap_o       = (state_q == ST_WAIT) && (ack_i == tog_o);
  assign wait_miss_o = (state_q == ST_WAIT) && (ack_i != tog_o);
  assign idx_o       = idx_q;

  // Length is live on the bus while its own nibble is being taken.
  assign len_src    = (idx_q == IDX_W'(1)) ? data_i : len_o;
  assign total_nibs = IDX_W'(2) + IDX_W'(payload_nibbles(len_src, MAX_BYTES));
  assign last_nib   = (idx_q != '0) && (idx_q + IDX_W'(1) == total_nibs);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sel_n_o <= 1'b1;
      tog_o   <= 1'b1;
      idx_q   <= '0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
      id_o    <= '0;
      len_o   <= '0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_WAIT;
          sel_n_o <= 1'b0;
          tog_o   <= 1'b0;
          idx_q   <= '0;
        end
        ST_WAIT: if (cap_o) begin
          if (idx_q == IDX_W'(0)) id_o  <= data_i;
          if (idx_q == IDX_W'(1)) len_o <= data_i;
          if (last_nib) begin
            state_q <= ST_IDLE;
            sel_n_o <= 1'b1;
            tog_o   <= 1'b1;
            done_o  <= 1'b1;
          end else begin
            tog_o <= ~tog_o;
            idx_q <= idx_q + IDX_W'(1);
          end
        end else if (expire_i) begin
          state_q <= ST_IDLE;
          sel_n_o <= 1'b1;
          tog_o   <= 1'b1;
          err_o   <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
    idle_o |-> (sel_n_o && tog_o));
  assert_select_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    launch_o |=> (!sel_n_o && !tog_o));
  assert_toggle_after_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_o && !last_nib) |=> (tog_o != $past(tog_o)) && !sel_n_o);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_done_lines_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (sel_n_o && tog_o));
  assert_abort_lines_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (sel_n_o && tog_o && !done_o));

endmodule

// File: rtl/nib_handshake_reader.sv
module nib_handshake_reader #(
  parameter int MAX_BYTES = 32,
  parameter int TMO_W     = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [TMO_W-1:0]       timeout_i,
  input  logic                   ack_i,
  input  logic [3:0]             data_i,
  output logic                   sel_n_o,
  output logic                   tog_o,
  output logic                   done_o,
  output logic                   err_o,
  output logic [3:0]             id_o,
  output logic [3:0]             len_o,
  output logic [8*MAX_BYTES-1:0] payload_o
);

  localparam int IDX_W = $clog2(2 * MAX_BYTES + 3);

  logic             launch_w, cap_w, miss_w, idle_w, expire_w;
  logic [IDX_W-1:0] idx_w;
  logic             pay_we_w;

  assign pay_we_w = cap_w && (idx_w >= IDX_W'(2));

  hsr_seq #(.MAX_BYTES(MAX_BYTES), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ack_i(ack_i), .data_i(data_i),
    .expire_i(expire_w), .sel_n_o(sel_n_o), .tog_o(tog_o), .launch_o(launch_w),
    .cap_o(cap_w), .wait_miss_o(miss_w), .idle_o(idle_w), .idx_o(idx_w),
    .done_o(done_o), .err_o(err_o), .id_o(id_o), .len_o(len_o)
  );

  hsr_timer #(.TMO_W(TMO_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear_i(idle_w || cap_w), .tick_i(miss_w),
    .limit_i(timeout_i), .expire_o(expire_w)
  );

  hsr_packer #(.MAX_BYTES(MAX_BYTES), .IDX_W(IDX_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .clear_i(launch_w), .we_i(pay_we_w),
    .idx_i(idx_w), .nib_i(data_i), .payload_o(payload_o)
  );

  // A completion and an abort never coincide.
  assert_done_err_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));

endmodule

// File: tb/sim_nib_handshake_reader.sv
module sim_nib_handshake_reader;
  localparam int MB = 6;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [TW-1:0] tmo = TW'(20);
  logic ack = 1'b1;
  logic [3:0] dat = 4'h0;
  logic sel_n, tog, done, err;
  logic [3:0] id, len;
  logic [8*MB-1:0] payload;

  int n_checks = 0;
  int n_fail = 0;
  logic [3:0] nibs [40];
  int dev_delay = 0;
  int silent_at = 1000;

  always #5 clk = ~clk;

  nib_handshake_reader #(.MAX_BYTES(MB), .TMO_W(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .timeout_i(tmo), .ack_i(ack),
    .data_i(dat), .sel_n_o(sel_n), .tog_o(tog), .done_o(done), .err_o(err),
    .id_o(id), .len_o(len), .payload_o(payload)
  );

  // Peripheral model: reacts on falling edges, follows toggle after dev_delay.
  initial begin
    int idx = 0;
    int wcnt = 0;
    forever begin
      @(negedge clk);
      if (sel_n) begin
        ack = 1'b1; idx = 0; wcnt = 0; dat = 4'h0;
      end else if (tog != ack) begin
        if (idx < 40) dat = ~nibs[idx];
        if (idx >= silent_at || idx >= 40) begin
        end else if (wcnt >= dev_delay) begin
          dat = nibs[idx]; ack = tog; idx++; wcnt = 0;
        end else wcnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [8*MB-1:0] exp_payload(input int nbytes);
    logic [8*MB-1:0] r = '0;
    for (int b = 0; b < MB; b++)
      if (b < nbytes) r[8*b +: 8] = {nibs[2+2*b], nibs[3+2*b]};
    return r;
  endfunction

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic run_xfer(input logic [3:0] did, input logic [3:0] blen,
                          input int dly, input bit extra_start);
    int nb;
    int n;
    nibs[0] = did; nibs[1] = blen;
    for (int k = 2; k < 40; k++) nibs[k] = 4'((int'(did) * 7 + k * 5 + int'(blen)) & 15);
    dev_delay = dly; silent_at = 1000;
    nb = (int'(blen) > MB) ? MB : int'(blen);
    pulse_start();
    n = 0;
    while (!done && !err && n < 2000) begin
      @(negedge clk); n++;
      start = (extra_start && n == 5);
    end
    start = 1'b0;
    chk(done && !err, "R5 done_seen", {err, done}, 2'b01);
    chk(id == did, "R4 id", id, did);
    chk(len == blen, "R4 len", len, blen);
    chk(payload == exp_payload(nb), "R6 R3 payload", payload, exp_payload(nb));
    chk(sel_n && tog, "R8 lines_at_done", {sel_n, tog}, 2'b11);
    // Length rule: cycles bounded by nibble count; verify done ends after 2+2*nb nibbles
    @(negedge clk);
    chk(!done, "R8 done_one_cycle", done, 1'b0);
    chk(sel_n && tog, "R1 idle_lines", {sel_n, tog}, 2'b11);
  endtask

  // R5: count the toggles seen during one read (2+2*nb nibbles => 1+2*nb toggles)
  task automatic count_toggles(input logic [3:0] blen);
    int t = 0;
    logic prev;
    int nb;
    nibs[0] = 4'h3; nibs[1] = blen;
    dev_delay = 1; silent_at = 1000;
    nb = (int'(blen) > MB) ? MB : int'(blen);
    pulse_start();
    prev = tog;
    while (!done && !err) begin
      @(negedge clk);
      if (!done && tog != prev) t++;
      prev = tog;
    end
    chk(t == 1 + 2 * nb, "R5 R3 toggle_count", t, 1 + 2 * nb);
  endtask

  task automatic run_silent(input int lim, input int at);
    int n;
    nibs[0] = 4'h9; nibs[1] = 4'h4;
    dev_delay = 0; silent_at = at; tmo = TW'(lim);
    pulse_start();
    n = 0;
    while (!err && !done && n < 500) begin
      @(negedge clk); n++;
    end
    chk(err && !done, "R7 abort", {err, done}, 2'b10);
    if (at == 0) chk(n == lim, "R7 abort_cycle", n, lim);
    chk(sel_n && tog, "R7 lines_after_abort", {sel_n, tog}, 2'b11);
    @(negedge clk);
    chk(!err, "R7 err_one_cycle", err, 1'b0);
    silent_at = 1000; tmo = TW'(20);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        n_checks++; n_fail++;
        $display("FAIL watchdog R5 actual=%0d expected<150000", cyc);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
      end
    end
  end

  initial begin
    for (int k = 0; k < 40; k++) nibs[k] = 4'h0;
    repeat (3) @(negedge clk);
    chk(sel_n && tog && !done && !err, "R1 reset_lines", {sel_n, tog, done, err}, 4'b1100);
    chk(id == 0 && len == 0 && payload == 0, "R1 reset_outputs", payload, 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(!sel_n && !tog, "R2 select_after_start", {sel_n, tog}, 2'b00);
    while (!done && !err) @(negedge clk);
    repeat (2) @(negedge clk);

    for (int d = 0; d < 4; d += (d == 1) ? 2 : 1)
      for (int l = 0; l < 16; l++)
        run_xfer(4'((l * 3 + d) & 15), 4'(l), d, 1'b0);

    run_xfer(4'hA, 4'h5, 3, 1'b1);   // R2: start while busy ignored
    count_toggles(4'h0);
    count_toggles(4'h4);
    count_toggles(4'hF);              // capped at MB bytes

    run_silent(1, 0);
    run_silent(5, 0);
    run_silent(9, 0);
    run_silent(6, 3);
    run_silent(4, 8);
    run_xfer(4'h7, 4'h2, 0, 1'b0);    // recovers after abort

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule